// File: doc/BRIEF.md
# Segment Descriptor Check and Translate

This block performs segment-based address translation of the protected-mode kind. It keeps a small table of 64-bit segment descriptors, filled through a write port. A load request presents a 16-bit selector. The block fetches the descriptor that the selector names, checks that it can be loaded, and caches the unpacked base, limit, type and flag fields for later use.

Each later access presents an offset, an access kind and a size. The block checks the cached segment for presence, for permission for the access kind, and for the limit. The limit check covers granularity scaling and expand-down segments. One cycle after the request, the block returns either a 32-bit linear address or a fault code.

Descriptor layout, by bit position:
- `[15:0]` limit low.
- `[39:16]` base low.
- `[47:40]` attribute byte: type in `[3:0]`, S in bit 4, privilege in `[6:5]`, present in bit 7.
- `[51:48]` limit high.
- `[55:52]` flags: available in bit 0, reserved in bit 1, D in bit 2, G in bit 3.
- `[63:56]` base high.

Top module: `seg_xlate`

## Requirements
- R1: After reset every output is zero. The cached segment is invalid, so an access made before any successful load returns fault code 1.
- R2: The table entry at `wr_idx` takes `wr_data` on `wr_en`. A load uses selector bits `[15:3]` as the table index and ignores bits `[2:0]`. An index that is not below ENTRIES fails the load with code 2.
- R3: A load of an in-range entry whose present bit (bit 47) is 0 fails with code 1. A load of an entry that is present but has S (bit 44) equal to 0 fails with code 3. Not-present takes priority over S=0.
- R4: `ld_done` pulses one cycle after `ld_req`, together with `ld_fault`. `seg_info` then shows `{flags, attribute}` as fetched. A successful load sets the accessed bit (bit 40) in the stored entry, so a later load of that entry shows it. If a write and that update hit the same entry in the same cycle, the write wins.
- R5: `acc_valid` pulses one cycle after `acc_req`. With no fault, `acc_lin` is base + offset modulo 2^32, where the base is taken from descriptor bits `[63:56]` and `[39:16]`.
- R6: The limit is `{[51:48],[15:0]}`. When G (bit 55) is 0 the effective limit is that value. When G is 1 it is the value followed by 12'hFFF.
- R7: For an expand-up or code segment, the access passes the limit check only when offset + 2^size − 1 is at most the effective limit. The sum is formed without wrapping. `acc_size` 0 to 3 means 1, 2, 4 or 8 bytes.
- R8: For an expand-down data segment (type bit 3 = 0, type bit 2 = 1), the access passes only when the offset is above the effective limit and the last byte is at most the upper bound. The upper bound is 32'hFFFF when D (bit 54) is 0 and 32'hFFFFFFFF when D is 1.
- R9: `acc_kind` is 0 for read, 1 for write, 2 for execute, and 3 is reserved and always faults. On a data segment a read is allowed, a write needs type bit 1, and execute faults with code 3.
- R10: On a code segment (type bit 3 = 1) execute is allowed, a read needs type bit 1, and a write faults with code 3.
- R11: The access fault priority is 1 (no valid segment), then 3 (type), then 2 (limit). `acc_lin` is 0 whenever the fault code is not 0.
- R12: A failed load invalidates the cached segment, so later accesses fault with code 1 until a load succeeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Table write strobe |
| wr_idx | input | IW | Table entry to write |
| wr_data | input | 64 | Descriptor to store |
| ld_req | input | 1 | Load the segment named by `ld_sel` |
| ld_sel | input | 16 | Selector |
| acc_req | input | 1 | Access request |
| acc_kind | input | 2 | 0 read, 1 write, 2 execute |
| acc_size | input | 2 | Log2 of the byte count |
| acc_off | input | 32 | Offset within the segment |
| ld_done | output | 1 | Load result strobe |
| ld_fault | output | 2 | Load fault code |
| seg_info | output | 12 | Fetched flags and attribute byte |
| acc_valid | output | 1 | Access result strobe |
| acc_fault | output | 2 | Access fault code |
| acc_lin | output | 32 | Linear address |

## Verification
The bench uses the default ENTRIES of 8. At that size every table slot holds a distinct descriptor kind: null, read/write data, readable code, execute-only code, both expand-down variants, a system descriptor, and a flat segment that wraps the base. A selector index of 8 then reaches the out-of-range load path. Offsets are chosen at exactly the effective limit, one byte past it, and at the 64 KB and 4 GB bounds. Multi-byte sizes make the last byte, rather than the first, decide the result.

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int ENTRIES = 8,
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [63:0] wr_data,
  input  logic        ld_req,
  input  logic [15:0] ld_sel,
  input  logic        acc_req,
  input  logic [1:0]  acc_kind,
  input  logic [1:0]  acc_size,
  input  logic [31:0] acc_off,
  output logic        ld_done,
  output logic [1:0]  ld_fault,
  output logic [11:0] seg_info,
  output logic        acc_valid,
  output logic [1:0]  acc_fault,
  output logic [31:0] acc_lin
);

  logic [63:0] tbl [ENTRIES];

  logic        c_ok;
  logic [31:0] c_base;
  logic [19:0] c_lim;
  logic        c_g;
  logic        c_d;
  logic [3:0]  c_type;

  wire [2:0]  sel_unused = ld_sel[2:0];
  wire [12:0] ld_index   = ld_sel[15:3];
  wire [IW-1:0] li       = ld_index[IW-1:0];
  wire        in_rng     = ld_index < 13'(ENTRIES);
  wire [63:0] desc       = tbl[li];
  wire [7:0]  d_attr     = desc[47:40];
  wire [3:0]  d_flags    = desc[55:52];

  logic [1:0] ld_code;
  always_comb begin
    if (!in_rng)        ld_code = 2'd2;
    else if (!d_attr[7]) ld_code = 2'd1;
    else if (!d_attr[4]) ld_code = 2'd3;
    else                ld_code = 2'd0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) tbl[i] <= '0;
    end else begin
      if (ld_req && ld_code == 2'd0) tbl[li][40] <= 1'b1;
      if (wr_en) tbl[wr_idx] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_ok     <= 1'b0;
      c_base   <= '0;
      c_lim    <= '0;
      c_g      <= 1'b0;
      c_d      <= 1'b0;
      c_type   <= '0;
      ld_done  <= 1'b0;
      ld_fault <= '0;
      seg_info <= '0;
    end else begin
      ld_done  <= ld_req;
      ld_fault <= ld_req ? ld_code : 2'd0;
      if (ld_req) begin
        c_ok     <= (ld_code == 2'd0);
        c_base   <= {desc[63:56], desc[39:16]};
        c_lim    <= {desc[51:48], desc[15:0]};
        c_g      <= d_flags[3];
        c_d      <= d_flags[2];
        c_type   <= d_attr[3:0];
        seg_info <= in_rng ? {d_flags, d_attr} : 12'h000;
      end
    end
  end

  wire [31:0] eff     = c_g ? {c_lim, 12'hFFF} : {12'h000, c_lim};
  wire [2:0]  span    = 3'((4'd1 << acc_size) - 4'd1);
  wire [32:0] last    = {1'b0, acc_off} + {30'b0, span};
  wire        is_code = c_type[3];
  wire        edown   = !is_code && c_type[2];
  wire [31:0] ubound  = c_d ? 32'hFFFF_FFFF : 32'h0000_FFFF;
  wire        lim_ok  = edown ? (acc_off > eff && last <= {1'b0, ubound})
                              : (last <= {1'b0, eff});

  logic type_ok;
  always_comb begin
    case (acc_kind)
      2'd0:    type_ok = !is_code || c_type[1];
      2'd1:    type_ok = !is_code && c_type[1];
      2'd2:    type_ok = is_code;
      default: type_ok = 1'b0;
    endcase
  end

  wire [1:0] acc_code = !c_ok    ? 2'd1 :
                        !type_ok ? 2'd3 :
                        !lim_ok  ? 2'd2 : 2'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_valid <= 1'b0;
      acc_fault <= '0;
      acc_lin   <= '0;
    end else begin
      acc_valid <= acc_req;
      acc_fault <= acc_req ? acc_code : 2'd0;
      acc_lin   <= (acc_req && acc_code == 2'd0) ? c_base + acc_off : 32'h0;
    end
  end

endmodule

module seg_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ld_req,
  input logic        acc_req,
  input logic [1:0]  acc_kind,
  input logic        ld_done,
  input logic [11:0] seg_info,
  input logic        acc_valid,
  input logic [1:0]  acc_fault,
  input logic [31:0] acc_lin
);

  p_acc_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req |=> acc_valid);

  p_acc_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_req |=> !acc_valid && acc_fault == 2'd0);

  p_ld_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ld_req |=> ld_done);

  p_lin_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_fault != 2'd0) |-> acc_lin == 32'h0);

  p_code_nowrite_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && acc_kind == 2'd1 && seg_info[3]) |=> acc_fault != 2'd0);

  p_data_noexec_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && acc_kind == 2'd2 && !seg_info[3]) |=> acc_fault != 2'd0);

endmodule

bind seg_xlate seg_xlate_chk u_chk (.*);

// File: tb/seg_xlate_test.sv
`timescale 1ns/1ps
module seg_xlate_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic [63:0] wr_data = '0;
  logic        ld_req = 1'b0;
  logic [15:0] ld_sel = '0;
  logic        acc_req = 1'b0;
  logic [1:0]  acc_kind = '0;
  logic [1:0]  acc_size = '0;
  logic [31:0] acc_off = '0;
  logic        ld_done;
  logic [1:0]  ld_fault;
  logic [11:0] seg_info;
  logic        acc_valid;
  logic [1:0]  acc_fault;
  logic [31:0] acc_lin;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  seg_xlate #(.ENTRIES(8)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .ld_req(ld_req), .ld_sel(ld_sel), .acc_req(acc_req), .acc_kind(acc_kind),
    .acc_size(acc_size), .acc_off(acc_off), .ld_done(ld_done), .ld_fault(ld_fault),
    .seg_info(seg_info), .acc_valid(acc_valid), .acc_fault(acc_fault), .acc_lin(acc_lin)
  );

  function automatic logic [63:0] mk(input logic [31:0] b, input logic [19:0] l,
                                     input logic [7:0] a, input logic [3:0] f);
    return {b[31:24], f, l[19:16], a, b[23:0], l[15:0]};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input int idx, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'(idx); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load(input logic [15:0] s, input logic [1:0] exp, input string req);
    @(negedge clk);
    ld_req = 1'b1; ld_sel = s;
    @(negedge clk);
    ld_req = 1'b0;
    chk(req, {63'b0, ld_done}, 64'd1);
    chk(req, {62'b0, ld_fault}, {62'b0, exp});
  endtask

  task automatic access(input logic [1:0] k, input logic [1:0] sz, input logic [31:0] off,
                        input logic [1:0] ef, input logic [31:0] el, input string req);
    @(negedge clk);
    acc_req = 1'b1; acc_kind = k; acc_size = sz; acc_off = off;
    @(negedge clk);
    acc_req = 1'b0;
    chk(req, {63'b0, acc_valid}, 64'd1);
    chk(req, {62'b0, acc_fault}, {62'b0, ef});
    chk(req, {32'b0, acc_lin}, {32'b0, el});
  endtask

  // {sel, kind, size, offset, fault, linear, requirement}
  localparam logic [89:0] VEC [20] = '{
    {16'h0008, 2'd0, 2'd2, 32'h0000_0FFC, 2'd0, 32'h0001_0FFC, 4'd7},  // R7 last byte at limit
    {16'h0008, 2'd0, 2'd2, 32'h0000_0FFD, 2'd2, 32'h0,          4'd7},  // R7 one past
    {16'h0008, 2'd1, 2'd0, 32'h0000_0000, 2'd0, 32'h0001_0000, 4'd9},  // R9 write ok
    {16'h0008, 2'd2, 2'd0, 32'h0000_0000, 2'd3, 32'h0,          4'd9},  // R9 exec data
    {16'h0010, 2'd2, 2'd0, 32'h0001_0FFF, 2'd0, 32'h0041_0FFF, 4'd6},  // R6 G=1 top
    {16'h0010, 2'd2, 2'd0, 32'h0001_1000, 2'd2, 32'h0,          4'd6},  // R6 past
    {16'h0010, 2'd1, 2'd0, 32'h0000_0000, 2'd3, 32'h0,          4'd10}, // R10 write code
    {16'h0010, 2'd0, 2'd1, 32'h0000_0100, 2'd0, 32'h0040_0100, 4'd10}, // R10 readable
    {16'h0018, 2'd0, 2'd0, 32'h0000_0000, 2'd3, 32'h0,          4'd10}, // R10 exec-only read
    {16'h0018, 2'd2, 2'd0, 32'h0000_00FF, 2'd0, 32'h0000_10FF, 4'd10}, // R10 exec
    {16'h0020, 2'd0, 2'd0, 32'h0000_0FFF, 2'd2, 32'h0,          4'd8},  // R8 at limit
    {16'h0020, 2'd0, 2'd0, 32'h0000_1000, 2'd0, 32'h2000_1000, 4'd8},  // R8 above
    {16'h0020, 2'd0, 2'd2, 32'h0000_FFFC, 2'd0, 32'h2000_FFFC, 4'd8},  // R8 64K top
    {16'h0020, 2'd0, 2'd2, 32'h0000_FFFD, 2'd2, 32'h0,          4'd8},  // R8 past 64K
    {16'h0020, 2'd1, 2'd0, 32'h0000_0000, 2'd3, 32'h0,          4'd11}, // R11 type over limit
    {16'h0028, 2'd1, 2'd3, 32'hFFFF_FFF8, 2'd0, 32'h0000_00F8, 4'd8},  // R8 4G top, wrap
    {16'h0028, 2'd0, 2'd0, 32'h0000_1FFF, 2'd2, 32'h0,          4'd8},  // R8 G=1 limit
    {16'h003B, 2'd0, 2'd2, 32'h0000_2000, 2'd0, 32'h0000_1000, 4'd5},  // R5 base wrap
    {16'h0038, 2'd0, 2'd2, 32'hFFFF_FFFD, 2'd2, 32'h0,          4'd7},  // R7 no wrap of sum
    {16'h000F, 2'd0, 2'd0, 32'h0000_0800, 2'd0, 32'h0001_0800, 4'd2}   // R2 low bits ignored
  };

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", {63'b0, ld_done}, 64'd0);
    chk("R1", {52'b0, seg_info}, 64'd0);
    chk("R1", {63'b0, acc_valid}, 64'd0);
    chk("R1", {32'b0, acc_lin}, 64'd0);
    access(2'd0, 2'd0, 32'h0, 2'd1, 32'h0, "R1");

    put(1, mk(32'h0001_0000, 20'h00FFF, 8'h92, 4'h4));
    put(2, mk(32'h0040_0000, 20'h00010, 8'h9A, 4'hC));
    put(3, mk(32'h0000_1000, 20'h000FF, 8'h98, 4'h4));
    put(4, mk(32'h2000_0000, 20'h00FFF, 8'h94, 4'h0));
    put(5, mk(32'h0000_0100, 20'h00001, 8'h96, 4'hC));
    put(6, mk(32'h0000_0000, 20'h0FFFF, 8'h82, 4'h0));
    put(7, mk(32'hFFFF_F000, 20'hFFFFF, 8'h92, 4'hC));

    // R4 accessed bit written back
    load(16'h0008, 2'd0, "R4");
    chk("R4", {52'b0, seg_info}, 64'h492);
    load(16'h0008, 2'd0, "R4");
    chk("R4", {52'b0, seg_info}, 64'h493);

    // R5 no request, no strobe
    @(negedge clk);
    chk("R5", {63'b0, acc_valid}, 64'd0);

    // R3 not present beats S=0; S=0 alone
    load(16'h0000, 2'd1, "R3");
    access(2'd0, 2'd0, 32'h0, 2'd1, 32'h0, "R12");
    load(16'h0030, 2'd3, "R3");
    access(2'd0, 2'd0, 32'h0, 2'd1, 32'h0, "R12");
    // R2 index out of table
    load(16'h0040, 2'd2, "R2");
    chk("R2", {52'b0, seg_info}, 64'h0);
    access(2'd0, 2'd0, 32'h0, 2'd1, 32'h0, "R12");
    // R9 reserved kind
    load(16'h0008, 2'd0, "R4");
    access(2'd3, 2'd0, 32'h0, 2'd3, 32'h0, "R9");

    for (int i = 0; i < 20; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[i][3:0], i);
      load(VEC[i][89:74], 2'd0, tag);
      access(VEC[i][73:72], VEC[i][71:70], VEC[i][69:38], VEC[i][37:36], VEC[i][35:4], tag);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule